// File: doc/BRIEF.md
# Ring Oscillator Pair Max-Difference Selector

This block drives two configurable ring oscillators, called A and B. Each oscillator has three stages, and each stage picks one of two inverters, so a 3-bit word selects one of eight variants of each oscillator. After a start request, the block steps through every variant of A and then every variant of B. For each variant it waits a fixed settle time and then counts rising edges over a programmable gate window. It keeps the fastest and slowest variant of each oscillator. It then chooses the pairing that spreads the two frequencies furthest apart, and reports the response bit from the sign of that chosen difference.

A bypass mode compares the two oscillators at a single shared configuration word. This gives a plain two-oscillator comparison as a baseline. The chosen configuration words are driven back onto the oscillator control outputs once the search ends. The results stay put until a later request finishes.

Top module: `ro_pair_selector`

## Requirements
- R1: After reset, busy, done and resp are 0, and sel_a, sel_b, max_diff, cfg_a and cfg_b are all zero.
- R2: In search mode (fixed_mode=0) the block sets both cfg_a and cfg_b to 0 on start. It then steps cfg_a through 0,1,...,7 while cfg_b stays 0. After that it steps cfg_b through 0,1,...,7 while cfg_a stays at 7.
- R3: Each configuration is measured after a settle time of SETTLE_CYC cycles. The count is the number of rising edges seen on the oscillator input during gate_len consecutive cycles, and the configuration words do not change while a count runs.
- R4: For each oscillator the block tracks the largest and smallest count. When several configurations share a count, the lowest configuration index wins.
- R5: With d1 = maxA - minB and d2 = maxB - minA, the block picks (argmax A, argmin B) when d1 >= d2, and (argmin A, argmax B) otherwise. max_diff equals the larger of d1 and d2.
- R6: resp is 1 exactly when the A count of the chosen pair is strictly greater than its B count.
- R7: In bypass mode (fixed_mode=1) cfg_a and cfg_b both take fixed_cfg, and each oscillator is measured once. sel_a and sel_b then both equal fixed_cfg, max_diff is the absolute count difference, and resp follows R6.
- R8: When the search ends, done rises and cfg_a and cfg_b equal sel_a and sel_b. sel_a, sel_b, max_diff and resp keep their values until the next run completes, including during that run.
- R9: A start pulse while busy is ignored: the sweep in progress neither restarts nor changes.
- R10: busy rises the cycle after an accepted start, and a start is accepted only when the block is idle or done. done falls on that start, and done and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (accepted when idle or done) |
| fixed_mode | input | 1 | 1 = bypass search, use fixed_cfg for both oscillators |
| fixed_cfg | input | CFG_W | Configuration word used in bypass mode |
| gate_len | input | WIN_W | Edge-count window length in cycles |
| osc_a | input | 1 | Pulse input from oscillator A |
| osc_b | input | 1 | Pulse input from oscillator B |
| cfg_a | output | CFG_W | Stage-select word driven to oscillator A |
| cfg_b | output | CFG_W | Stage-select word driven to oscillator B |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Results valid, held until next start |
| sel_a | output | CFG_W | Chosen configuration of A |
| sel_b | output | CFG_W | Chosen configuration of B |
| max_diff | output | CNT_W | Edge-count difference of the chosen pair |
| resp | output | 1 | Response bit: 1 when A is faster in the chosen pair |

## Verification
A wrong internal state shows up at the ports at a definite point. A fault in a window count or in the extreme tracking only appears when done rises: the chosen indices or max_diff are off by an amount the bench can predict. The oscillator models run at periods that divide the gate window, so every count is exact. A sequencing fault shows up sooner: it shows in the cfg_a and cfg_b words logged while busy, within one measurement of the mistake. A fault in holding the results shows mid-run, because the bench compares sel_a, sel_b and max_diff with the previous result while the next sweep is still running.

// File: rtl/ro_sel_pkg.sv
package ro_sel_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_COUNT, S_STORE, S_EVAL, S_DONE
  } sel_state_t;

  // d1 >= d2  <=>  maxA + minA >= maxB + minB
  function automatic logic pair_a_side(input logic [31:0] mxa, input logic [31:0] mna,
                                       input logic [31:0] mxb, input logic [31:0] mnb);
    return ({1'b0, mxa} + {1'b0, mna}) >= ({1'b0, mxb} + {1'b0, mnb});
  endfunction

  // difference of the chosen pair, never negative once the side is picked
  function automatic logic [31:0] pair_gap(input logic a_side,
                                           input logic [31:0] mxa, input logic [31:0] mna,
                                           input logic [31:0] mxb, input logic [31:0] mnb);
    return a_side ? (mxa - mnb) : (mxb - mna);
  endfunction

endpackage

// File: rtl/ro_edge_counter.sv
module ro_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count
);
  logic sync1, sync2, prev;
  logic rise;

  assign rise = sync2 & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
      count <= '0;
    end else begin
      sync1 <= osc;
      sync2 <= sync1;
      prev  <= sync2;
      if (clr)            count <= '0;
      else if (en && rise) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ro_extreme_tracker.sv
module ro_extreme_tracker #(
  parameter int VAL_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [VAL_W-1:0] val,
  input  logic [IDX_W-1:0] idx,
  output logic [VAL_W-1:0] max_v,
  output logic [IDX_W-1:0] max_i,
  output logic [VAL_W-1:0] min_v,
  output logic [IDX_W-1:0] min_i
);
  logic have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have  <= 1'b0;
      max_v <= '0;
      max_i <= '0;
      min_v <= '0;
      min_i <= '0;
    end else if (clr) begin
      have <= 1'b0;
    end else if (upd) begin
      have <= 1'b1;
      // strict compares keep the earliest (lowest) index on ties
      if (!have || val > max_v) begin
        max_v <= val;
        max_i <= idx;
      end
      if (!have || val < min_v) begin
        min_v <= val;
        min_i <= idx;
      end
    end
  end
endmodule

// File: rtl/ro_pair_selector.sv
module ro_pair_selector
  import ro_sel_pkg::*;
#(
  parameter int CFG_W      = 3,
  parameter int CNT_W      = 16,
  parameter int WIN_W      = 16,
  parameter int SETTLE_CYC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fixed_mode,
  input  logic [CFG_W-1:0] fixed_cfg,
  input  logic [WIN_W-1:0] gate_len,
  input  logic             osc_a,
  input  logic             osc_b,
  output logic [CFG_W-1:0] cfg_a,
  output logic [CFG_W-1:0] cfg_b,
  output logic             busy,
  output logic             done,
  output logic [CFG_W-1:0] sel_a,
  output logic [CFG_W-1:0] sel_b,
  output logic [CNT_W-1:0] max_diff,
  output logic             resp
);
  localparam logic [CFG_W-1:0] LAST_CFG = CFG_W'((1 << CFG_W) - 1);
  localparam int               SET_W    = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_END  = SET_W'(SETTLE_CYC - 1);

  sel_state_t       state;
  logic             side_b;
  logic             mode_q;
  logic [CFG_W-1:0] fix_q;
  logic [CFG_W-1:0] idx;
  logic [SET_W-1:0] settle_cnt;
  logic [WIN_W-1:0] win_cnt;

  // named events for the checker
  logic start_ok, store_fire, eval_fire, count_active, win_last, meas_last;
  logic [CFG_W-1:0] first_cfg, next_idx;

  assign start_ok     = start && (state == S_IDLE || state == S_DONE);
  assign store_fire   = (state == S_STORE);
  assign eval_fire    = (state == S_EVAL);
  assign count_active = (state == S_COUNT);
  assign win_last     = ({1'b0, win_cnt} + 1'b1) >= {1'b0, gate_len};
  assign meas_last    = mode_q || (idx == LAST_CFG);
  assign first_cfg    = mode_q ? fix_q : '0;
  assign next_idx     = idx + 1'b1;

  logic [1:0]       osc_vec;
  logic [CNT_W-1:0] cnt  [2];
  logic [CNT_W-1:0] mx_v [2];
  logic [CNT_W-1:0] mn_v [2];
  logic [CFG_W-1:0] mx_i [2];
  logic [CFG_W-1:0] mn_i [2];

  assign osc_vec = {osc_b, osc_a};

  for (genvar g = 0; g < 2; g++) begin : g_osc
    ro_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .osc   (osc_vec[g]),
      .clr   (state == S_SETTLE),
      .en    (count_active),
      .count (cnt[g])
    );
    ro_extreme_tracker #(.VAL_W(CNT_W), .IDX_W(CFG_W)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .upd   (store_fire && (side_b == 1'(g))),
      .val   (cnt[g]),
      .idx   (idx),
      .max_v (mx_v[g]),
      .max_i (mx_i[g]),
      .min_v (mn_v[g]),
      .min_i (mn_i[g])
    );
  end

  logic        a_side;
  logic [31:0] gap32;
  assign a_side = pair_a_side(32'(mx_v[0]), 32'(mn_v[0]), 32'(mx_v[1]), 32'(mn_v[1]));
  assign gap32  = pair_gap(a_side, 32'(mx_v[0]), 32'(mn_v[0]), 32'(mx_v[1]), 32'(mn_v[1]));

  assign busy = !(state == S_IDLE || state == S_DONE);
  assign done = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      side_b     <= 1'b0;
      mode_q     <= 1'b0;
      fix_q      <= '0;
      idx        <= '0;
      settle_cnt <= '0;
      win_cnt    <= '0;
      cfg_a      <= '0;
      cfg_b      <= '0;
      sel_a      <= '0;
      sel_b      <= '0;
      max_diff   <= '0;
      resp       <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start_ok) begin
            mode_q     <= fixed_mode;
            fix_q      <= fixed_cfg;
            idx        <= fixed_mode ? fixed_cfg : '0;
            cfg_a      <= fixed_mode ? fixed_cfg : '0;
            cfg_b      <= fixed_mode ? fixed_cfg : '0;
            side_b     <= 1'b0;
            settle_cnt <= '0;
            state      <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (settle_cnt == SET_END) begin
            win_cnt <= '0;
            state   <= S_COUNT;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        S_COUNT: begin
          if (win_last) state <= S_STORE;
          else          win_cnt <= win_cnt + 1'b1;
        end
        S_STORE: begin
          settle_cnt <= '0;
          if (!meas_last) begin
            idx <= next_idx;
            if (side_b) cfg_b <= next_idx;
            else        cfg_a <= next_idx;
            state <= S_SETTLE;
          end else if (!side_b) begin
            side_b <= 1'b1;
            idx    <= first_cfg;
            cfg_b  <= first_cfg;
            state  <= S_SETTLE;
          end else begin
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          sel_a    <= a_side ? mx_i[0] : mn_i[0];
          sel_b    <= a_side ? mn_i[1] : mx_i[1];
          cfg_a    <= a_side ? mx_i[0] : mn_i[0];
          cfg_b    <= a_side ? mn_i[1] : mx_i[1];
          max_diff <= gap32[CNT_W-1:0];
          resp     <= a_side && (mx_v[0] > mn_v[1]);
          state    <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ro_pair_selector_chk.sv
module ro_pair_selector_chk #(
  parameter int CFG_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             resp,
  input logic             mode_q,
  input logic             eval_fire,
  input logic             count_active,
  input logic [CFG_W-1:0] cfg_a,
  input logic [CFG_W-1:0] cfg_b,
  input logic [CFG_W-1:0] sel_a,
  input logic [CFG_W-1:0] sel_b,
  input logic [CNT_W-1:0] max_diff
);
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_fire |=> ($stable(sel_a) && $stable(sel_b) && $stable(max_diff) && $stable(resp)));

  p_done_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cfg_a == sel_a && cfg_b == sel_b));

  p_resp_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp |-> (max_diff != '0));

  p_fixed_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |-> (sel_a == sel_b));

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_active |=> (!count_active || ($stable(cfg_a) && $stable(cfg_b))));
endmodule

bind ro_pair_selector ro_pair_selector_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .resp         (resp),
  .mode_q       (mode_q),
  .eval_fire    (eval_fire),
  .count_active (count_active),
  .cfg_a        (cfg_a),
  .cfg_b        (cfg_b),
  .sel_a        (sel_a),
  .sel_b        (sel_b),
  .max_diff     (max_diff)
);

// File: tb/ro_pair_selector_tb.sv
module ro_pair_selector_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fixed_mode = 1'b0;
  logic [2:0]  fixed_cfg = '0;
  logic [15:0] gate_len = 16'd40;
  logic        osc_a = 1'b0, osc_b = 1'b0;
  logic [2:0]  cfg_a, cfg_b, sel_a, sel_b;
  logic        busy, done, resp;
  logic [15:0] max_diff;

  always #(CLK_P/2) clk = ~clk;

  ro_pair_selector u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fixed_mode(fixed_mode),
    .fixed_cfg(fixed_cfg), .gate_len(gate_len), .osc_a(osc_a), .osc_b(osc_b),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .busy(busy), .done(done), .sel_a(sel_a),
    .sel_b(sel_b), .max_diff(max_diff), .resp(resp)
  );

  int per_a [8];
  int per_b [8];
  int ph_a = 0, ph_b = 0;
  logic [2:0] lc_a = '0, lc_b = '0;

  // oscillator models: period in clock cycles chosen by the config word
  always @(posedge clk) begin
    #1;
    if (cfg_a != lc_a) ph_a = 0; else ph_a = (ph_a + 1) % per_a[cfg_a];
    lc_a = cfg_a;
    osc_a = (ph_a < per_a[cfg_a] / 2);
    if (cfg_b != lc_b) ph_b = 0; else ph_b = (ph_b + 1) % per_b[cfg_b];
    lc_b = cfg_b;
    osc_b = (ph_b < per_b[cfg_b] / 2);
  end

  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_tab(input int ta [8], input int tb_ [8]);
    for (int i = 0; i < 8; i++) begin
      per_a[i] = ta[i];
      per_b[i] = tb_[i];
    end
  endtask

  task automatic run(input logic mode, input int fcfg, input int w, input logic poke);
    int la [16];
    int lb [16];
    int nla = 0, nlb = 0, pa = -1, pb = -1, n = 0;
    int ca [8];
    int cb [8];
    int mxa, mna, mxb, mnb, ixa, ina, ixb, inb, ea, eb, ed, er;
    int old_sa, old_sb, old_md;
    int lo, hi;
    old_sa = sel_a; old_sb = sel_b; old_md = max_diff;
    @(negedge clk);
    fixed_mode = mode; fixed_cfg = 3'(fcfg); gate_len = 16'(w); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R10 busy after start", busy, 1);
    while (!done && n < 5000) begin
      if (busy && cfg_a != pa) begin if (nla < 16) la[nla] = cfg_a; nla++; pa = cfg_a; end
      if (busy && cfg_b != pb) begin if (nlb < 16) lb[nlb] = cfg_b; nlb++; pb = cfg_b; end
      if (poke && n == 100) start = 1'b1;
      if (poke && n == 101) start = 1'b0;
      if (poke && n == 150) begin
        chk(sel_a == 3'(old_sa) && sel_b == 3'(old_sb), "R8 sel held mid-run", sel_a, old_sa);
        chk(max_diff == 16'(old_md), "R8 max_diff held mid-run", max_diff, old_md);
      end
      @(negedge clk);
      n++;
    end
    if (!done) begin
      chk(1'b0, "watchdog", n, 5000);
      return;
    end
    // expected values from the requirements
    lo = mode ? fcfg : 0;
    hi = mode ? fcfg : 7;
    for (int i = 0; i < 8; i++) begin ca[i] = w / per_a[i]; cb[i] = w / per_b[i]; end
    mxa = -1; mna = 1 << 30; mxb = -1; mnb = 1 << 30;
    ixa = 0; ina = 0; ixb = 0; inb = 0;
    for (int i = lo; i <= hi; i++) begin
      if (ca[i] > mxa) begin mxa = ca[i]; ixa = i; end
      if (ca[i] < mna) begin mna = ca[i]; ina = i; end
      if (cb[i] > mxb) begin mxb = cb[i]; ixb = i; end
      if (cb[i] < mnb) begin mnb = cb[i]; inb = i; end
    end
    if (mxa - mnb >= mxb - mna) begin
      ea = ixa; eb = inb; ed = mxa - mnb; er = (mxa > mnb) ? 1 : 0;
    end else begin
      ea = ina; eb = ixb; ed = mxb - mna; er = 0;
    end
    chk(sel_a == 3'(ea), "R4 R5 sel_a", sel_a, ea);
    chk(sel_b == 3'(eb), "R4 R5 sel_b", sel_b, eb);
    chk(max_diff == 16'(ed), "R3 R5 max_diff", max_diff, ed);
    chk(resp == 1'(er), "R6 resp", resp, er);
    chk(cfg_a == sel_a && cfg_b == sel_b, "R8 cfg follows selection", cfg_a, sel_a);
    if (mode) begin
      chk(nla == 1 && la[0] == fcfg, "R7 cfg_a fixed word", la[0], fcfg);
      chk(nlb == 1 && lb[0] == fcfg, "R7 cfg_b fixed word", lb[0], fcfg);
    end else begin
      chk(nla == 8, "R2 R9 cfg_a step count", nla, 8);
      chk(nlb == 8, "R2 R9 cfg_b step count", nlb, 8);
      for (int i = 0; i < 8 && i < nla && i < nlb; i++) begin
        chk(la[i] == i, "R2 cfg_a order", la[i], i);
        chk(lb[i] == i, "R2 cfg_b order", lb[i], i);
      end
    end
    repeat (3) @(negedge clk);
    chk(done && !busy, "R8 done held", done, 1);
  endtask

  initial begin
    int ta [8];
    int tb_ [8];
    ta = '{8, 4, 10, 2, 8, 5, 20, 10};
    tb_ = '{10, 10, 5, 8, 20, 4, 10, 8};
    set_tab(ta, tb_);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !resp, "R1 flags", {busy, done, resp}, 0);
    chk(sel_a == 0 && sel_b == 0, "R1 selections", sel_a, 0);
    chk(max_diff == 0 && cfg_a == 0 && cfg_b == 0, "R1 diff and cfg", max_diff, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", busy, 0);

    run(1'b0, 0, 40, 1'b0);             // A side wins: R5 R6
    set_tab(tb_, ta);
    run(1'b0, 0, 40, 1'b1);             // B side wins, R8 mid-run hold, R9 ignored start
    ta = '{4, 4, 4, 4, 4, 4, 4, 4};
    tb_ = '{5, 2, 2, 10, 40, 2, 40, 8};
    set_tab(ta, tb_);
    run(1'b0, 0, 40, 1'b0);             // R4 lowest-index ties
    ta = '{8, 4, 8, 8, 8, 8, 8, 8};
    tb_ = '{8, 8, 8, 4, 8, 8, 8, 8};
    set_tab(ta, tb_);
    run(1'b0, 0, 40, 1'b0);             // R5 d1 == d2 tie picks A side
    ta = '{8, 8, 8, 8, 8, 8, 8, 8};
    set_tab(ta, ta);
    run(1'b0, 0, 40, 1'b0);             // R6 all equal -> resp 0, gap 0
    ta = '{8, 4, 10, 2, 8, 5, 20, 10};
    tb_ = '{10, 10, 5, 8, 20, 4, 10, 8};
    set_tab(ta, tb_);
    run(1'b1, 5, 40, 1'b0);             // R7 bypass mode
    run(1'b1, 3, 40, 1'b0);             // R7 bypass, A faster
    run(1'b0, 0, 80, 1'b0);             // R3 longer window

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule